// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block sits between a synchronous host and an external pseudo-static RAM that has a 19-bit flat address, an 8-bit data bus, an active-low chip enable, an active-low write enable and one pin that acts as output enable during an access and as a refresh strobe while chip enable is high. The host issues single reads and writes on a valid/ready request port. Read results come back on a one-cycle response strobe. Every timing figure is a parameter counted in clock cycles.

After reset the controller waits out the supply-settling interval. It then runs a fixed number of dummy chip-enable cycles before it raises `init_done` and begins accepting requests. A free-running interval counter raises a refresh request roughly every 15.6 µs. The controller serves it with one low pulse on the output-enable/refresh pin while chip enable stays high. It always returns that pin high at the end of an access and holds it high for a command delay before the pulse falls, which re-arms the memory's refresh logic.

Top module: `psram_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ram_ce_n`, `ram_we_n` and `ram_oe_rfsh_n` are 1, `ram_dq` is not driven, and `req_ready`, `init_done` and `rsp_valid` are 0.
- R2: `ram_ce_n` does not fall until at least PWRUP_CYCLES cycles after reset. Exactly INIT_DUMMIES chip-enable pulses, each with write enable and output enable high, occur before `init_done` rises. `req_ready` is never 1 while `init_done` is 0.
- R3: Every low pulse on `ram_ce_n` lasts exactly T_CE cycles.
- R4: `ram_ce_n` stays high for at least T_PRE cycles between two low pulses.
- R5: During a write, `ram_we_n` is low and `ram_oe_rfsh_n` is high for the whole chip-enable pulse. `ram_dq` carries the request data, and `ram_addr` holds the request address without change.
- R6: During a read, `ram_oe_rfsh_n` is low, `ram_we_n` is high and the controller does not drive `ram_dq`. The byte present on `ram_dq` in the last low cycle of chip enable is returned with `rsp_valid` high for one cycle, in the first cycle that chip enable is high again.
- R7: A refresh is one low pulse on `ram_oe_rfsh_n` of exactly T_FAP cycles while `ram_ce_n` stays high. The falling edge comes at least T_RFD cycles after chip enable last rose.
- R8: One refresh is issued per REF_INTERVAL cycles, whether the request port is idle or saturated. A pending refresh is taken before a waiting request, and an access in progress is never cut short.
- R9: Whenever `ram_ce_n` rises, `ram_oe_rfsh_n` is high in that same cycle.
- R10: Each accepted handshake (`req_valid` and `req_ready` both 1 at a clock edge) produces exactly one chip-enable pulse, and no other pulse occurs after `init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 8 | Read data |
| init_done | output | 1 | Power-up sequence complete |
| ram_ce_n | output | 1 | Memory chip enable, active low |
| ram_we_n | output | 1 | Memory write enable, active low |
| ram_oe_rfsh_n | output | 1 | Output enable during access, refresh strobe in standby |
| ram_addr | output | 19 | Memory address |
| ram_dq | inout | 8 | Memory data bus |

## Verification
The bench targets the shared output-enable/refresh pin. A design that left it low when chip enable rose after a read would never re-arm refresh. One that shortened the command delay or the pulse width would produce a refresh the memory ignores or botches. The refresh rate is measured twice, once with an idle port and once under back-to-back traffic. A controller that let requests starve refresh would come up short in the second window. The bench also counts the power-up dummies and the chip-enable widths, and it reads back writes at the lowest and highest addresses and on both sides of a row boundary. A wrong bus turnaround or sample point shows up as mismatched read data.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_ACC,
    ST_PRE,
    ST_RFD,
    ST_RFSH,
    ST_RFP
  } psram_st_e;
endpackage

// File: rtl/psram_phase_cnt.sv
module psram_phase_cnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= W'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_ref_timer.sv
module psram_ref_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int W = $clog2(INTERVAL);

  logic [W-1:0] cnt_q;
  logic         tick;

  assign tick = (cnt_q == W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int T_CE         = 6,
  parameter int T_PRE        = 4,
  parameter int T_RFD        = 3,
  parameter int T_FAP        = 5,
  parameter int T_FP         = 5,
  parameter int PWRUP_CYCLES = 5000,
  parameter int INIT_DUMMIES = 8,
  parameter int REF_INTERVAL = 780
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              init_done,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_rfsh_n,
  output logic [ADDR_W-1:0] ram_addr,
  inout  wire  [DATA_W-1:0] ram_dq
);
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam int DUM_W = $clog2(INIT_DUMMIES + 1);

  psram_st_e         state_q, state_d;
  logic              ph_load, ph_zero;
  logic [CNT_W-1:0]  ph_val;
  logic              ref_pend, ref_ack;
  logic [DUM_W-1:0]  dum_left_q;
  logic              dummy_q, dq_oe_q;
  logic [DATA_W-1:0] dq_out_q;

  psram_phase_cnt #(.W(CNT_W), .RST_VAL(PWRUP_CYCLES - 1)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  psram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  // Requests are taken only when no dummy or refresh is owed.
  assign req_ready = (state_q == ST_IDLE) && init_done && !ref_pend;
  assign ram_dq    = dq_oe_q ? dq_out_q : {DATA_W{1'bz}};

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    ref_ack = 1'b0;
    case (state_q)
      ST_PWRUP: if (ph_zero) state_d = ST_IDLE;
      ST_IDLE: begin
        if (dum_left_q != '0 || (req_valid && req_ready)) begin
          state_d = ST_ACC;
          ph_load = 1'b1;
          ph_val  = CNT_W'(T_CE - 1);
        end else if (init_done && ref_pend) begin
          state_d = ST_RFD;
          ph_load = 1'b1;
          ph_val  = CNT_W'(T_RFD - 1);
        end
      end
      ST_ACC: if (ph_zero) begin
        state_d = ST_PRE;
        ph_load = 1'b1;
        ph_val  = CNT_W'(T_PRE - 1);
      end
      ST_PRE: if (ph_zero) state_d = ST_IDLE;
      ST_RFD: if (ph_zero) begin
        state_d = ST_RFSH;
        ph_load = 1'b1;
        ph_val  = CNT_W'(T_FAP - 1);
      end
      ST_RFSH: if (ph_zero) begin
        state_d = ST_RFP;
        ph_load = 1'b1;
        ph_val  = CNT_W'(T_FP - 1);
      end
      ST_RFP: if (ph_zero) begin
        state_d = ST_IDLE;
        ref_ack = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_PWRUP;
      ram_ce_n      <= 1'b1;
      ram_we_n      <= 1'b1;
      ram_oe_rfsh_n <= 1'b1;
      ram_addr      <= '0;
      dq_oe_q       <= 1'b0;
      dq_out_q      <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      dum_left_q    <= DUM_W'(INIT_DUMMIES);
      dummy_q       <= 1'b0;
      init_done     <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= 1'b0;
      if (state_q == ST_IDLE && state_d == ST_ACC) begin
        ram_ce_n <= 1'b0;
        if (dum_left_q != '0) begin
          dum_left_q    <= dum_left_q - 1'b1;
          dummy_q       <= 1'b1;
          ram_we_n      <= 1'b1;
          ram_oe_rfsh_n <= 1'b1;
          dq_oe_q       <= 1'b0;
          ram_addr      <= '0;
        end else begin
          dummy_q       <= 1'b0;
          ram_addr      <= req_addr;
          ram_we_n      <= !req_write;
          ram_oe_rfsh_n <= req_write;
          dq_oe_q       <= req_write;
          dq_out_q      <= req_wdata;
        end
      end
      if (state_q == ST_ACC && ph_zero) begin
        ram_ce_n      <= 1'b1;
        ram_we_n      <= 1'b1;
        ram_oe_rfsh_n <= 1'b1;
        dq_oe_q       <= 1'b0;
        if (ram_we_n && !dummy_q) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= ram_dq;
        end
      end
      if (state_q == ST_PRE && ph_zero && dum_left_q == '0) init_done <= 1'b1;
      if (state_q == ST_RFD && ph_zero)  ram_oe_rfsh_n <= 1'b0;
      if (state_q == ST_RFSH && ph_zero) ram_oe_rfsh_n <= 1'b1;
    end
  end
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int T_CE   = 6,
  parameter int T_PRE  = 4,
  parameter int T_RFD  = 3,
  parameter int T_FAP  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic              ram_oe_rfsh_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              req_ready,
  input logic              init_done,
  input logic              rsp_valid
);
  logic [15:0] lo_cnt, hi_cnt, oe_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      oe_lo_cnt <= '0;
    end else begin
      lo_cnt    <= ram_ce_n ? '0 : lo_cnt + 1'b1;
      hi_cnt    <= !ram_ce_n ? '0 : (hi_cnt == 16'hFFFF ? hi_cnt : hi_cnt + 1'b1);
      oe_lo_cnt <= ram_oe_rfsh_n ? '0 : oe_lo_cnt + 1'b1;
    end
  end

  AST_INIT_GATES_READY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> init_done);                                           // R2
  AST_CE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (ram_ce_n && !$past(ram_ce_n)) |-> (lo_cnt == 16'(T_CE)));           // R3
  AST_CE_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && $past(ram_ce_n)) |-> (hi_cnt >= 16'(T_PRE)));          // R4
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && !ram_we_n) |-> ram_oe_rfsh_n);                         // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && !$past(ram_ce_n)) |-> $stable(ram_addr));              // R5
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && !ram_oe_rfsh_n) |-> ram_we_n);                         // R6
  AST_RSP_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (ram_ce_n && !$past(ram_ce_n)));                       // R6
  AST_REFRESH_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (ram_oe_rfsh_n && !$past(ram_oe_rfsh_n) && ram_ce_n && $past(ram_ce_n))
      |-> (oe_lo_cnt == 16'(T_FAP)));                                    // R7
  AST_REFRESH_DELAY: assert property (@(posedge clk) disable iff (rst)
    (!ram_oe_rfsh_n && $past(ram_oe_rfsh_n) && ram_ce_n) |-> (hi_cnt >= 16'(T_RFD))); // R7
  AST_REARM_ON_CE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_ce_n) |-> ram_oe_rfsh_n);                                  // R9
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .ADDR_W(ADDR_W), .T_CE(T_CE), .T_PRE(T_PRE), .T_RFD(T_RFD), .T_FAP(T_FAP)
) u_chk (
  .clk(clk), .rst(rst), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
  .ram_oe_rfsh_n(ram_oe_rfsh_n), .ram_addr(ram_addr), .req_ready(req_ready),
  .init_done(init_done), .rsp_valid(rsp_valid)
);

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;
  localparam int T_CE = 6, T_PRE = 4, T_RFD = 3, T_FAP = 5, T_FP = 5;
  localparam int PWRUP = 5000, DUMMIES = 8, REF_IV = 780;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, init_done;
  logic [7:0]  rsp_rdata;
  logic        ram_ce_n, ram_we_n, ram_oe_rfsh_n;
  logic [18:0] ram_addr;
  wire  [7:0]  ram_dq;

  always #10 clk = ~clk;

  psram_ctrl #(.T_CE(T_CE), .T_PRE(T_PRE), .T_RFD(T_RFD), .T_FAP(T_FAP), .T_FP(T_FP),
               .PWRUP_CYCLES(PWRUP), .INIT_DUMMIES(DUMMIES), .REF_INTERVAL(REF_IV)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .init_done(init_done),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_rfsh_n(ram_oe_rfsh_n),
    .ram_addr(ram_addr), .ram_dq(ram_dq)
  );

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model (unwritten bytes read as addr[7:0]^8'h5A)
  logic [7:0] mem [int];
  logic [18:0] m_addr;
  logic [7:0]  m_rd, m_wbuf;
  logic        m_wpend = 0, m_drive = 0, prev_ce = 1;
  assign ram_dq = m_drive ? m_rd : 8'bz;

  always @(negedge clk) begin
    if (!ram_ce_n && prev_ce) begin
      m_addr = ram_addr;
      m_rd   = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : (ram_addr[7:0] ^ 8'h5A);
    end
    if (!ram_ce_n && !ram_we_n) begin m_wbuf = ram_dq; m_wpend = 1; end
    if (ram_ce_n && m_wpend) begin mem[int'(m_addr)] = m_wbuf; m_wpend = 0; end
    m_drive = !ram_ce_n && ram_we_n && !ram_oe_rfsh_n;
    prev_ce = ram_ce_n;
  end

  // ---------------- pin monitor
  int cyc = 0, lo_len = 0, hi_len = 0, oe_lo_len = 0;
  int dummies = 0, first_fall = -1, post_pulses = 0, ref_cnt = 0;
  int v_ready = 0, v_wr = 0;
  logic p_ce = 1, p_oe = 1;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (!ram_ce_n && p_ce) begin
        if (first_fall < 0) first_fall = cyc;
        if (!init_done) begin
          dummies++;
          check(ram_we_n && ram_oe_rfsh_n, "R2 dummy pins", ram_we_n, 1);
        end else post_pulses++;
        check(hi_len >= T_PRE, "R4 precharge", hi_len, T_PRE);
      end
      if (ram_ce_n && !p_ce) begin
        check(lo_len == T_CE, "R3 ce width", lo_len, T_CE);
        check(ram_oe_rfsh_n, "R9 oe high at ce rise", ram_oe_rfsh_n, 1);
      end
      if (!ram_oe_rfsh_n && p_oe && ram_ce_n) begin
        ref_cnt++;
        check(hi_len >= T_RFD, "R7 command delay", hi_len, T_RFD);
      end
      if (ram_oe_rfsh_n && !p_oe && ram_ce_n && p_ce)
        check(oe_lo_len == T_FAP, "R7 refresh width", oe_lo_len, T_FAP);
      if (!ram_ce_n && !ram_we_n && !ram_oe_rfsh_n) v_wr++;
      if (req_ready && !init_done) v_ready++;
      lo_len    = ram_ce_n ? 0 : lo_len + 1;
      hi_len    = ram_ce_n ? hi_len + 1 : 0;
      oe_lo_len = ram_oe_rfsh_n ? 0 : oe_lo_len + 1;
      p_ce = ram_ce_n;
      p_oe = ram_oe_rfsh_n;
    end
  end

  // ---------------- scoreboard
  logic [26:0] exp_q[$];
  logic [7:0]  shadow [int];
  int n_req = 0;

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R6 unexpected response", rsp_rdata, -1);
      else begin
        logic [26:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata == e[7:0], "R6 read data", rsp_rdata, e[7:0]);
      end
    end
  end

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    n_req++;
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back({a, shadow.exists(int'(a)) ? shadow[int'(a)] : (a[7:0] ^ 8'h5A)});
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int r0, c0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(ram_ce_n && ram_we_n && ram_oe_rfsh_n, "R1 strobes high", {ram_ce_n, ram_we_n, ram_oe_rfsh_n}, 7);
    check(ram_dq === 8'bz, "R1 bus released", ram_dq, 0);
    check(!req_ready && !init_done && !rsp_valid, "R1 status low", {req_ready, init_done, rsp_valid}, 0);
    rst = 0;
    @(negedge clk);
    check(ram_ce_n && !init_done, "R1 after release", {ram_ce_n, init_done}, 2);
    while (!init_done) @(negedge clk);
    check(first_fall >= PWRUP, "R2 power-up wait", first_fall, PWRUP);
    check(dummies == DUMMIES, "R2 dummy count", dummies, DUMMIES);

    // R5 / R6 writes then reads at corners and across a row boundary
    issue(1, 19'h00000, 8'hA5);
    issue(1, 19'h7FFFF, 8'h3C);
    issue(1, 19'h007FF, 8'h11);
    issue(1, 19'h00800, 8'h22);
    issue(1, 19'h12345, 8'h99);
    issue(0, 19'h00000, 0);
    issue(0, 19'h7FFFF, 0);
    issue(0, 19'h007FF, 0);
    issue(0, 19'h00800, 0);
    issue(0, 19'h12345, 0);
    issue(0, 19'h0ABCD, 0);
    issue(1, 19'h12345, 8'h5E);
    issue(0, 19'h12345, 0);
    repeat (30) @(negedge clk);

    // R8 idle refresh rate
    r0 = ref_cnt;
    repeat (10 * REF_IV) @(negedge clk);
    check(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R8 idle refresh rate", ref_cnt - r0, 10);

    // R8 refresh rate under saturated traffic
    r0 = ref_cnt; c0 = cyc;
    for (int i = 0; i < 240; i++) begin
      logic [18:0] a;
      a = 19'((i * 2731) & 19'h7FFFF);
      if (i % 2 == 0) issue(1, a, 8'(i * 7 + 3));
      else issue(0, 19'(((i - 1) * 2731) & 19'h7FFFF), 0);
    end
    begin
      int exp_r;
      exp_r = (cyc - c0) / REF_IV;
      check(ref_cnt - r0 >= exp_r - 1 && ref_cnt - r0 <= exp_r + 1,
            "R8 refresh under load", ref_cnt - r0, exp_r);
    end
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
    check(post_pulses == n_req, "R10 one pulse per request", post_pulses, n_req);
    check(v_ready == 0, "R2 ready before init", v_ready, 0);
    check(v_wr == 0, "R5 oe high during write", v_wr, 0);
    summary();
  end
endmodule